// File: doc/BRIEF.md
# Fractional UART Baud-Rate Generator

This block turns a functional clock into the timing enables of a UART. A programmable divisor, made of a 16-bit whole part and a 6-bit fraction counted in 1/64 steps, sets the spacing of a sample tick. The bit tick then fires on every 16th, 8th or 3rd sample tick, depending on the oversampling select. To get a baud rate B from a clock F with oversampling factor K, software writes the whole part of F/(K·B). It writes the remainder times 64, rounded to the nearest integer, as the fraction.

The whole part, the fraction and the oversampling select are written into pending registers. They reach the running counters only after a separate line-control write strobe. Even then they wait until the serial engine reports that no character is in flight. While a character runs, the old timing stays in force. The serial engine can also re-align the sample phase, for example on a detected start bit or at the start of a transmission.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset the pending and active whole divisors and fractions are zero, the fractional accumulator is zero, and 16x oversampling (code 2'b00) is selected. Both ticks are low.
- R2: While the active whole divisor is zero, `sample_tick` and `bit_tick` stay low, and the timing counters and accumulator are held at zero.
- R3: Writes through `int_we`, `frac_we` or `ovs_we` change only the pending values. The tick timing stays unchanged until a commit takes place.
- R4: When `lcr_we` is high in a cycle with `char_busy` low, the active values take the pending values at that clock edge. The accumulator and bit phase clear, and the first `sample_tick` appears in the N-th cycle after that edge, where N is the new whole divisor.
- R5: When `lcr_we` is high while `char_busy` is high, the commit is held. It takes effect at the first edge where `char_busy` is low, using the pending values present at that edge. Until then the old timing continues.
- R6: Each sample period lasts N clocks, plus one clock when the 6-bit accumulator overflows as the fraction F is added at the end of a period. The accumulator keeps the sum modulo 64, so any 64 consecutive sample periods span exactly 64·N+F clocks.
- R7: `bit_tick` is high together with every K-th `sample_tick`, counted from the last commit or phase restart. K is 16 for code 2'b00, 8 for 2'b01, 3 for 2'b10, and 16 for the spare code 2'b11.
- R8: `phase_restart` reloads the sample counter so that the next `sample_tick` comes N cycles after the edge. It also clears the bit phase and leaves the accumulator as it is. A commit in the same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_we | input | 1 | Write strobe for the pending whole divisor |
| int_wdata | input | 16 | Pending whole divisor value |
| frac_we | input | 1 | Write strobe for the pending fraction |
| frac_wdata | input | 6 | Pending fraction, in 1/64 units |
| ovs_we | input | 1 | Write strobe for the pending oversampling select |
| ovs_wdata | input | 2 | Oversampling code: 00=16x, 01=8x, 10=3x, 11=16x |
| lcr_we | input | 1 | Line-control write strobe that commits pending values |
| char_busy | input | 1 | A character is being sent or received |
| phase_restart | input | 1 | Re-align the sample and bit phase |
| sample_tick | output | 1 | One-cycle enable per sample period |
| bit_tick | output | 1 | One-cycle enable per bit period |

## Verification
Some rules are checked on every cycle. Ticks stay silent under a zero divisor, and every bit tick falls on a sample tick. The bit phase stays inside the selected factor. The active values do not move while a character is busy or while no commit is pending, and a commit on an idle line copies the pending values. Two ticks never sit back to back when the divisor exceeds one, and a restart quietens the next cycle. Only the bench scenarios show the exact spacing of ticks: the 64-period fractional sum, the latency of the first tick after a commit or restart, the bit length for each oversampling code, and a deferred commit landing at the end of a busy character.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;

  typedef enum logic [1:0] {
    OVS_X16 = 2'b00,
    OVS_X8  = 2'b01,
    OVS_X3  = 2'b10,
    OVS_SPARE = 2'b11
  } ovs_sel_e;

  // samples per bit for a select code; the spare code behaves as 16x
  function automatic logic [4:0] ovs_factor(input logic [1:0] sel);
    case (ovs_sel_e'(sel))
      OVS_X8:  return 5'd8;
      OVS_X3:  return 5'd3;
      default: return 5'd16;
    endcase
  endfunction

endpackage

// File: rtl/fbg_divisor_regs.sv
module fbg_divisor_regs #(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              int_we,
  input  logic [INT_W-1:0]  int_wdata,
  input  logic              frac_we,
  input  logic [FRAC_W-1:0] frac_wdata,
  input  logic              ovs_we,
  input  logic [1:0]        ovs_wdata,
  input  logic              lcr_we,
  input  logic              char_busy,
  output logic [INT_W-1:0]  pend_int,
  output logic [INT_W-1:0]  act_int,
  output logic [FRAC_W-1:0] act_frac,
  output logic [1:0]        act_ovs,
  output logic              commit_pend,
  output logic              load_evt
);

  logic [FRAC_W-1:0] pend_frac;
  logic [1:0]        pend_ovs;

  // a commit fires on an idle line, either fresh or carried over
  assign load_evt = (lcr_we | commit_pend) & ~char_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_int  <= '0;
      pend_frac <= '0;
      pend_ovs  <= 2'b00;
    end else begin
      if (int_we)  pend_int  <= int_wdata;
      if (frac_we) pend_frac <= frac_wdata;
      if (ovs_we)  pend_ovs  <= ovs_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_int     <= '0;
      act_frac    <= '0;
      act_ovs     <= 2'b00;
      commit_pend <= 1'b0;
    end else if (load_evt) begin
      act_int     <= pend_int;
      act_frac    <= pend_frac;
      act_ovs     <= pend_ovs;
      commit_pend <= 1'b0;
    end else if (lcr_we) begin
      commit_pend <= 1'b1;
    end
  end

endmodule

// File: rtl/fbg_sample_timer.sv
module fbg_sample_timer #(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INT_W-1:0]  act_int,
  input  logic [FRAC_W-1:0] act_frac,
  input  logic [INT_W-1:0]  load_int,
  input  logic              load_evt,
  input  logic              phase_restart,
  output logic              div_valid,
  output logic              sample_tick
);

  localparam logic [INT_W-1:0] ONE = {{(INT_W-1){1'b0}}, 1'b1};

  logic [INT_W-1:0]  cnt_q;
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   step;
  logic [INT_W-1:0]  reload;

  // fractional accumulator step: MSB is the overflow carry
  function automatic logic [FRAC_W:0] frac_step(input logic [FRAC_W-1:0] a,
                                                input logic [FRAC_W-1:0] f);
    return {1'b0, a} + {1'b0, f};
  endfunction

  // count value that gives a period of n clocks
  function automatic logic [INT_W-1:0] period_start(input logic [INT_W-1:0] n);
    return (n == '0) ? '0 : n - ONE;
  endfunction

  assign div_valid   = |act_int;
  assign sample_tick = div_valid && (cnt_q == '0);
  assign step        = frac_step(acc_q, act_frac);
  assign reload      = period_start(act_int) + {{(INT_W-1){1'b0}}, step[FRAC_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else if (load_evt) begin
      cnt_q <= period_start(load_int);
      acc_q <= '0;
    end else if (!div_valid) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else if (phase_restart) begin
      cnt_q <= period_start(act_int);
    end else if (cnt_q == '0) begin
      cnt_q <= reload;
      acc_q <= step[FRAC_W-1:0];
    end else begin
      cnt_q <= cnt_q - ONE;
    end
  end

endmodule

// File: rtl/fbg_bit_phase.sv
module fbg_bit_phase #(
  parameter int PH_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      ovs_sel,
  input  logic            div_valid,
  input  logic            load_evt,
  input  logic            phase_restart,
  input  logic            sample_tick,
  output logic [PH_W-1:0] phase_q,
  output logic            bit_tick
);

  import frac_baud_pkg::*;

  localparam logic [PH_W-1:0] PH_ONE = {{(PH_W-1){1'b0}}, 1'b1};

  logic [PH_W-1:0] factor;
  logic            last_sample;

  assign factor      = PH_W'(ovs_factor(ovs_sel));
  assign last_sample = (phase_q == factor - PH_ONE);
  assign bit_tick    = sample_tick && last_sample;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (load_evt || !div_valid || phase_restart) begin
      phase_q <= '0;
    end else if (sample_tick) begin
      phase_q <= last_sample ? '0 : phase_q + PH_ONE;
    end
  end

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 6,
  parameter int PH_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              int_we,
  input  logic [INT_W-1:0]  int_wdata,
  input  logic              frac_we,
  input  logic [FRAC_W-1:0] frac_wdata,
  input  logic              ovs_we,
  input  logic [1:0]        ovs_wdata,
  input  logic              lcr_we,
  input  logic              char_busy,
  input  logic              phase_restart,
  output logic              sample_tick,
  output logic              bit_tick
);

  // named internal events, observed by the bound checker
  logic [INT_W-1:0]  pend_int;
  logic [INT_W-1:0]  act_int;
  logic [FRAC_W-1:0] act_frac;
  logic [1:0]        act_ovs;
  logic              commit_pend;
  logic              load_evt;
  logic              div_valid;
  logic [PH_W-1:0]   phase_q;

  fbg_divisor_regs #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .int_we      (int_we),
    .int_wdata   (int_wdata),
    .frac_we     (frac_we),
    .frac_wdata  (frac_wdata),
    .ovs_we      (ovs_we),
    .ovs_wdata   (ovs_wdata),
    .lcr_we      (lcr_we),
    .char_busy   (char_busy),
    .pend_int    (pend_int),
    .act_int     (act_int),
    .act_frac    (act_frac),
    .act_ovs     (act_ovs),
    .commit_pend (commit_pend),
    .load_evt    (load_evt)
  );

  fbg_sample_timer #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_timer (
    .clk           (clk),
    .rst_n         (rst_n),
    .act_int       (act_int),
    .act_frac      (act_frac),
    .load_int      (pend_int),
    .load_evt      (load_evt),
    .phase_restart (phase_restart),
    .div_valid     (div_valid),
    .sample_tick   (sample_tick)
  );

  fbg_bit_phase #(.PH_W(PH_W)) u_phase (
    .clk           (clk),
    .rst_n         (rst_n),
    .ovs_sel       (act_ovs),
    .div_valid     (div_valid),
    .load_evt      (load_evt),
    .phase_restart (phase_restart),
    .sample_tick   (sample_tick),
    .phase_q       (phase_q),
    .bit_tick      (bit_tick)
  );

endmodule

// File: rtl/frac_baud_gen_chk.sv
module frac_baud_gen_chk #(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 6,
  parameter int PH_W   = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lcr_we,
  input logic              char_busy,
  input logic              phase_restart,
  input logic              sample_tick,
  input logic              bit_tick,
  input logic [INT_W-1:0]  pend_int,
  input logic [INT_W-1:0]  act_int,
  input logic [FRAC_W-1:0] act_frac,
  input logic [1:0]        act_ovs,
  input logic              commit_pend,
  input logic              load_evt,
  input logic [PH_W-1:0]   phase_q
);

  import frac_baud_pkg::*;

  localparam logic [INT_W-1:0] ONE = {{(INT_W-1){1'b0}}, 1'b1};

  a_r1_reset_clean: assert property (@(posedge clk)
    (rst_n && !$past(rst_n)) |-> (act_int == '0 && act_ovs == 2'b00 && !sample_tick));

  a_r2_zero_div_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (act_int == '0) |-> (!sample_tick && !bit_tick));

  a_r3_hold_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (!lcr_we && !commit_pend) |=> ($stable(act_int) && $stable(act_frac) && $stable(act_ovs)));

  a_r4_idle_commit_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (lcr_we && !char_busy) |=> (act_int == $past(pend_int)));

  a_r5_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    char_busy |=> ($stable(act_int) && $stable(act_frac) && $stable(act_ovs)));

  a_r6_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_tick && act_int > ONE && !phase_restart && !load_evt) |=> !sample_tick);

  a_r7_bit_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> sample_tick);

  a_r7_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q < PH_W'(ovs_factor(act_ovs)));

  a_r8_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_restart && !load_evt && act_int > ONE) |=> (!sample_tick && !bit_tick));

endmodule

bind frac_baud_gen frac_baud_gen_chk #(.INT_W(INT_W), .FRAC_W(FRAC_W), .PH_W(PH_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .lcr_we        (lcr_we),
  .char_busy     (char_busy),
  .phase_restart (phase_restart),
  .sample_tick   (sample_tick),
  .bit_tick      (bit_tick),
  .pend_int      (pend_int),
  .act_int       (act_int),
  .act_frac      (act_frac),
  .act_ovs       (act_ovs),
  .commit_pend   (commit_pend),
  .load_evt      (load_evt),
  .phase_q       (phase_q)
);

// File: tb/frac_baud_gen_tb.sv
module frac_baud_gen_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        int_we = 1'b0;
  logic [15:0] int_wdata = '0;
  logic        frac_we = 1'b0;
  logic [5:0]  frac_wdata = '0;
  logic        ovs_we = 1'b0;
  logic [1:0]  ovs_wdata = '0;
  logic        lcr_we = 1'b0;
  logic        char_busy = 1'b0;
  logic        phase_restart = 1'b0;
  logic        sample_tick;
  logic        bit_tick;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string cur_req = "R1";

  frac_baud_gen u_dut (
    .clk(clk), .rst_n(rst_n),
    .int_we(int_we), .int_wdata(int_wdata),
    .frac_we(frac_we), .frac_wdata(frac_wdata),
    .ovs_we(ovs_we), .ovs_wdata(ovs_wdata),
    .lcr_we(lcr_we), .char_busy(char_busy),
    .phase_restart(phase_restart),
    .sample_tick(sample_tick), .bit_tick(bit_tick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- behavioural reference model ----------------
  int m_pi, m_pf, m_po;      // pending whole, fraction, code
  int m_ai, m_af, m_ao;      // active
  bit m_req;                 // held commit
  int m_wait;                // clocks left before the next sample tick
  int m_frac_sum;            // running fraction total, modulo 64
  int m_smp;                 // samples seen in the current bit

  function automatic int spb(input int code);
    if (code == 1) return 8;
    if (code == 2) return 3;
    return 16;
  endfunction

  function automatic bit exp_sample();
    return (m_ai != 0) && (m_wait == 0);
  endfunction

  function automatic bit exp_bit();
    return exp_sample() && (m_smp + 1 == spb(m_ao));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pi = 0; m_pf = 0; m_po = 0;
      m_ai = 0; m_af = 0; m_ao = 0;
      m_req = 0; m_wait = 0; m_frac_sum = 0; m_smp = 0;
    end else begin
      automatic bit was_tick = exp_sample();
      automatic bit commit = (lcr_we || m_req) && !char_busy;
      if (commit) begin
        m_ai = m_pi; m_af = m_pf; m_ao = m_po; m_req = 0;
        m_wait = (m_pi > 0) ? m_pi - 1 : 0;
        m_frac_sum = 0; m_smp = 0;
      end else begin
        if (lcr_we) m_req = 1;
        if (m_ai == 0) begin
          m_wait = 0; m_frac_sum = 0; m_smp = 0;
        end else if (phase_restart) begin
          m_wait = m_ai - 1; m_smp = 0;
        end else if (was_tick) begin
          m_frac_sum = m_frac_sum + m_af;
          m_wait = m_ai - 1;
          if (m_frac_sum >= 64) begin
            m_wait = m_wait + 1;
            m_frac_sum = m_frac_sum - 64;
          end
          m_smp = (m_smp + 1 == spb(m_ao)) ? 0 : m_smp + 1;
        end else begin
          m_wait = m_wait - 1;
        end
      end
      if (int_we)  m_pi = int_wdata;
      if (frac_we) m_pf = frac_wdata;
      if (ovs_we)  m_po = ovs_wdata;
    end
  end

  // compare on every cycle, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      checks++;
      if (sample_tick !== exp_sample() || bit_tick !== exp_bit()) begin
        errors++;
        $display("FAIL %s model compare at cycle %0d: actual s=%0b b=%0b expected s=%0b b=%0b",
                 cur_req, cycles, sample_tick, bit_tick, exp_sample(), exp_bit());
      end
    end
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected at most %0d", cycles, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input string req, input string what, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_div(input int whole, input int frac, input int code);
    int_we = 1; int_wdata = 16'(whole);
    frac_we = 1; frac_wdata = 6'(frac);
    ovs_we = 1; ovs_wdata = 2'(code);
    @(negedge clk);
    int_we = 0; frac_we = 0; ovs_we = 0;
  endtask

  // pulse the commit; returns at the first cycle after the edge
  task automatic pulse_commit();
    lcr_we = 1;
    @(negedge clk);
    lcr_we = 0;
  endtask

  // cycles from "now" (counted as 1) until sample_tick is seen
  task automatic latency_to_sample(output int k);
    k = 1;
    while (!sample_tick && k < 70000) begin @(negedge clk); k++; end
  endtask

  task automatic latency_to_bit(output int k);
    k = 1;
    while (!bit_tick && k < 70000) begin @(negedge clk); k++; end
  endtask

  // clocks spanned by n sample periods, starting at the next tick
  task automatic span_samples(input int n, output int span);
    int seen;
    while (!sample_tick) @(negedge clk);
    span = 0; seen = 0;
    while (seen < n) begin
      @(negedge clk); span++;
      if (sample_tick) seen++;
    end
  endtask

  task automatic span_bits(input int n, output int span);
    int seen;
    while (!bit_tick) @(negedge clk);
    span = 0; seen = 0;
    while (seen < n) begin
      @(negedge clk); span++;
      if (bit_tick) seen++;
    end
  endtask

  task automatic count_ticks(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      if (sample_tick || bit_tick) cnt++;
      @(negedge clk);
    end
  endtask

  // ---------------- scenarios ----------------
  initial begin
    int k, span, cnt;
    step(3);
    cur_req = "R1";
    check("R1", "sample_tick in reset", int'(sample_tick), 0);
    rst_n = 1;
    @(negedge clk);
    check("R1", "ticks after reset", int'(sample_tick | bit_tick), 0);

    cur_req = "R2";
    count_ticks(20, cnt);
    check("R2", "ticks with zero active divisor", cnt, 0);

    // pending writes alone
    cur_req = "R3";
    write_div(4, 16, 0);
    count_ticks(30, cnt);
    check("R3", "ticks before commit", cnt, 0);

    cur_req = "R4";
    pulse_commit();
    latency_to_sample(k);
    check("R4", "first sample after commit", k, 4);

    cur_req = "R6";
    span_samples(64, span);
    check("R6", "64 periods N=4 F=16", span, 64 * 4 + 16);

    // spacing with a fraction near one
    write_div(1, 63, 0);
    pulse_commit();
    span_samples(64, span);
    check("R6", "64 periods N=1 F=63", span, 64 + 63);

    write_div(1, 0, 0);
    pulse_commit();
    count_ticks(10, cnt);
    check("R6", "N=1 F=0 ticks every cycle", cnt, 10);

    // oversampling codes
    cur_req = "R7";
    write_div(5, 0, 2);
    pulse_commit();
    span_bits(4, span);
    check("R7", "bit length 3x N=5", span, 4 * 15);
    write_div(3, 0, 1);
    pulse_commit();
    span_bits(3, span);
    check("R7", "bit length 8x N=3", span, 3 * 24);
    write_div(2, 0, 3);
    pulse_commit();
    span_bits(3, span);
    check("R7", "bit length spare code N=2", span, 3 * 32);
    write_div(2, 0, 0);
    pulse_commit();
    latency_to_bit(k);
    check("R7", "first bit after commit 16x N=2", k, 32);

    // commit during a busy character
    cur_req = "R5";
    write_div(5, 0, 2);
    pulse_commit();
    char_busy = 1;
    write_div(7, 0, 2);
    pulse_commit();
    span_samples(4, span);
    check("R5", "old period kept while busy", span, 20);
    step(13);
    span_samples(2, span);
    check("R5", "still old period while busy", span, 10);
    write_div(9, 0, 2);
    char_busy = 0;
    @(negedge clk);
    latency_to_sample(k);
    check("R5", "deferred commit uses value at release", k, 9);
    span_samples(3, span);
    check("R5", "new period after release", span, 27);

    // phase restart
    cur_req = "R8";
    write_div(10, 0, 0);
    pulse_commit();
    step(37);
    phase_restart = 1;
    @(negedge clk);
    phase_restart = 0;
    latency_to_sample(k);
    check("R8", "sample after restart", k, 10);
    step(25);
    phase_restart = 1;
    @(negedge clk);
    phase_restart = 0;
    latency_to_bit(k);
    check("R8", "bit after restart", k, 160);

    // restart keeps the accumulator: 64 periods still add F
    write_div(3, 40, 0);
    pulse_commit();
    step(50);
    phase_restart = 1;
    @(negedge clk);
    phase_restart = 0;
    span_samples(64, span);
    check("R8", "fraction sum after restart", span, 64 * 3 + 40);

    // back to a zero divisor
    cur_req = "R2";
    write_div(0, 5, 0);
    pulse_commit();
    count_ticks(40, cnt);
    check("R2", "ticks after committing zero", cnt, 0);

    step(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule